// File: doc/BRIEF.md
# Testable Reversible Master-Slave Flip-Flop

This block is an edge-triggered D storage element made from two level-sensitive stages. Each stage uses the controlled-swap primitive, a three-input gate that passes its control bit through unchanged. The gate's other two outputs act as a pair of complementary 2:1 selectors. The master stage is transparent while the enable `en_i` is high. The slave stage is transparent while `en_i` is low and follows the master. The stored word therefore moves to `q_o` when `en_i` falls.

Each stage closes its hold loop through a second swap gate, which is steered by two control bits. With the normal setting, that gate copies the stored value back into the loop. With both control bits equal, the loop node is forced to that constant. This breaks the feedback so that the structure can be tested with all-zeros or all-ones vectors. The loop nodes of both stages are brought out as `m_fb_o` and `s_fb_o`.

The level behaviour is evaluated once per rising edge of `clk_i`, and `en_i` is sampled there. Mode controls are expected to change only while `en_i` is stable.

Top module: `rev_ms_dff`

## Requirements
- R1: While `rst_ni` is low, both stored words are zero, so `q_o`, `m_fb_o` and `s_fb_o` read zero under normal controls (control bit 0 = 0, bit 1 = 1, i.e. `2'b10`).
- R2: With both stages in normal mode, `q_o` takes a new value only at the first `clk_i` edge that samples `en_i` low after an edge that sampled it high. The new value is the `d_i` sampled at that earlier edge.
- R3: With both stages in normal mode, `q_o` is unchanged after any edge that samples `en_i` high, and after any edge that samples `en_i` low when the previous edge also sampled it low.
- R4: Under normal controls, a stage's loop node equals its stored word. While `en_i` is high, `m_fb_o` equals the `d_i` sampled at the latest edge.
- R5: With a stage's controls at `2'b11`, its loop node reads all ones. While that stage holds, it loads all ones at each edge.
- R6: With a stage's controls at `2'b00`, its loop node reads all zeros. While that stage holds, it loads all zeros at each edge.
- R7: With a stage's controls at `2'b01` (bit 0 = 1, bit 1 = 0), its loop node is the complement of the stored word. A holding stage inverts its word at every edge.
- R8: The master controls affect only the master loop and the slave controls affect only the slave loop. A transparent master with the slave forced still captures `d_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Evaluation clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Stage enable: master open when high, slave open when low |
| d_i | input | W | Data word |
| m_ctl_i | input | 2 | Master loop steering; bit 0 and bit 1 are the two gate controls |
| s_ctl_i | input | 2 | Slave loop steering, same encoding |
| q_o | output | W | Slave stored word |
| m_fb_o | output | W | Master loop node |
| s_fb_o | output | W | Slave loop node |

## Verification
The assertions check the per-stage rules on every cycle: an open stage captures its input, a normal stage holds, a forced stage loads the constant, an inverting stage toggles, and the output does not move while the master is open. Only the bench scenarios can show the end-to-end edge behaviour: the value launched at the fall of `en_i` is the last word seen while the master was open. The bench also shows the interplay of independent master and slave settings, and that reset clears the words mid-run.

// File: rtl/rmsff_pkg.sv
package rmsff_pkg;

  typedef struct packed {
    logic p;
    logic q;
    logic r;
  } swap3_t;

  // controlled swap: a passes, q/r are complementary selectors
  function automatic swap3_t swap3(input logic a, input logic b, input logic c);
    swap3_t o;
    o.p = a;
    o.q = (~a & b) | (a & c);
    o.r = (a & b) | (~a & c);
    return o;
  endfunction

  localparam logic [1:0] CTL_NORMAL = 2'b10;
  localparam logic [1:0] CTL_ONES   = 2'b11;
  localparam logic [1:0] CTL_ZEROS  = 2'b00;
  localparam logic [1:0] CTL_INVERT = 2'b01;

endpackage

// File: rtl/rmsff_tap.sv
module rmsff_tap
  import rmsff_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] st_i,
  input  logic         c1_i,
  input  logic         c2_i,
  output logic [W-1:0] copy_o,
  output logic [W-1:0] fb_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign copy_o[i] = swap3(st_i[i], c1_i, c2_i).p;
    assign fb_o[i]   = swap3(st_i[i], c1_i, c2_i).q;
  end

endmodule

// File: rtl/rmsff_latch.sv
module rmsff_latch
  import rmsff_pkg::*;
#(
  parameter int W      = 8,
  parameter bit POS_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  input  logic [1:0]   ctl_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] fb_o
);

  logic [W-1:0] st_q, st_d;
  logic         open_s;

  assign open_s = (en_i == POS_EN);

  rmsff_tap #(.W(W)) u_tap (
    .st_i  (st_q),
    .c1_i  (ctl_i[0]),
    .c2_i  (ctl_i[1]),
    .copy_o(q_o),
    .fb_o  (fb_o)
  );

  for (genvar i = 0; i < W; i++) begin : g_sel
    if (POS_EN) begin : g_pos
      assign st_d[i] = swap3(en_i, fb_o[i], d_i[i]).q;
    end else begin : g_neg
      assign st_d[i] = swap3(en_i, d_i[i], fb_o[i]).q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  // R4
  open_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_s |=> q_o == $past(d_i));

  // R3
  normal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_s && ctl_i == CTL_NORMAL) |=> $stable(q_o));

  // R5
  force_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_s && ctl_i == CTL_ONES) |=> q_o == '1);

  // R6
  force_zeros_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_s && ctl_i == CTL_ZEROS) |=> q_o == '0);

  // R7
  invert_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_s && ctl_i == CTL_INVERT) |=> q_o == ~$past(q_o));

endmodule

// File: rtl/rev_ms_dff.sv
module rev_ms_dff
  import rmsff_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  input  logic [1:0]   m_ctl_i,
  input  logic [1:0]   s_ctl_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] m_fb_o,
  output logic [W-1:0] s_fb_o
);

  logic [W-1:0] m_q;

  rmsff_latch #(.W(W), .POS_EN(1'b1)) u_master (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .d_i   (d_i),
    .ctl_i (m_ctl_i),
    .q_o   (m_q),
    .fb_o  (m_fb_o)
  );

  rmsff_latch #(.W(W), .POS_EN(1'b0)) u_slave (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .d_i   (m_q),
    .ctl_i (s_ctl_i),
    .q_o   (q_o),
    .fb_o  (s_fb_o)
  );

  // R3
  out_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && m_ctl_i == CTL_NORMAL && s_ctl_i == CTL_NORMAL) |=> $stable(q_o));

  // R2
  out_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && s_ctl_i == CTL_NORMAL) |=> q_o == $past(m_q));

endmodule

// File: tb/rev_ms_dff_tb.sv
module rev_ms_dff_tb;

  localparam int W = 8;

  typedef struct packed {
    logic         en;
    logic [W-1:0] d;
    logic [W-1:0] q;
    logic [W-1:0] mfb;
  } vec_t;

  // normal mode walk, from reset state; s_fb equals q in normal mode
  localparam vec_t TAB [10] = '{
    '{1'b1, 8'hA5, 8'h00, 8'hA5},
    '{1'b1, 8'h3C, 8'h00, 8'h3C},
    '{1'b0, 8'hFF, 8'h3C, 8'h3C},
    '{1'b0, 8'h11, 8'h3C, 8'h3C},
    '{1'b1, 8'h11, 8'h3C, 8'h11},
    '{1'b0, 8'h22, 8'h11, 8'h11},
    '{1'b1, 8'h80, 8'h11, 8'h80},
    '{1'b1, 8'h01, 8'h11, 8'h01},
    '{1'b0, 8'h01, 8'h01, 8'h01},
    '{1'b0, 8'hFE, 8'h01, 8'h01}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] d = '0;
  logic [1:0]   m_ctl = 2'b10;
  logic [1:0]   s_ctl = 2'b10;
  logic [W-1:0] q, m_fb, s_fb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rev_ms_dff #(.W(W)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .en_i   (en),
    .d_i    (d),
    .m_ctl_i(m_ctl),
    .s_ctl_i(s_ctl),
    .q_o    (q),
    .m_fb_o (m_fb),
    .s_fb_o (s_fb)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [W-1:0] dv, input logic [1:0] mc, input logic [1:0] sc);
    en = e; d = dv; m_ctl = mc; s_ctl = sc;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 q", q, 8'h00);
    chk("R1 m_fb", m_fb, 8'h00);
    chk("R1 s_fb", s_fb, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 normal walk
    for (int k = 0; k < 10; k++) begin
      step(TAB[k].en, TAB[k].d, 2'b10, 2'b10);
      chk("R2/R3 q", q, TAB[k].q);
      chk("R4 m_fb", m_fb, TAB[k].mfb);
      chk("R4 s_fb", s_fb, TAB[k].q);
    end

    // R5 both forced ones, state m=01 s=01
    step(1'b0, 8'h00, 2'b11, 2'b11);
    chk("R5 m_fb", m_fb, 8'hFF);
    chk("R5 q", q, 8'h01);
    chk("R5 s_fb", s_fb, 8'hFF);
    step(1'b0, 8'h00, 2'b11, 2'b11);
    chk("R5 q load", q, 8'hFF);
    step(1'b1, 8'h00, 2'b11, 2'b11);
    chk("R5 slave hold ones", q, 8'hFF);
    chk("R5 m_fb forced", m_fb, 8'hFF);

    // R6 both forced zeros, state m=00 s=FF
    step(1'b1, 8'h5A, 2'b00, 2'b00);
    chk("R6 q", q, 8'h00);
    chk("R6 m_fb", m_fb, 8'h00);
    chk("R6 s_fb", s_fb, 8'h00);
    step(1'b0, 8'h00, 2'b00, 2'b00);
    chk("R6 q launch", q, 8'h5A);
    step(1'b0, 8'h00, 2'b00, 2'b00);
    chk("R6 q zero", q, 8'h00);

    // R7 master inverting, slave normal, state m=00 s=00
    step(1'b0, 8'h77, 2'b01, 2'b10);
    chk("R7 m_fb", m_fb, 8'h00);
    chk("R7 q", q, 8'h00);
    step(1'b0, 8'h77, 2'b01, 2'b10);
    chk("R7 m_fb toggle", m_fb, 8'hFF);
    chk("R7 q", q, 8'hFF);

    // R8 master normal captures, slave forced ones, state m=00 s=FF
    step(1'b1, 8'hC3, 2'b10, 2'b11);
    chk("R8 m_fb", m_fb, 8'hC3);
    chk("R8 s_fb", s_fb, 8'hFF);
    chk("R8 q", q, 8'hFF);

    // R1 mid-run reset
    m_ctl = 2'b10; s_ctl = 2'b10;
    rst_n = 1'b0;
    #1;
    chk("R1 q async", q, 8'h00);
    chk("R1 m_fb async", m_fb, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule